// File: doc/BRIEF.md
# Bidirectional FIFO Port Controller with Mailbox Bypass

This block is the access decoder for one side of a device that carries two FIFOs in opposite directions between two independently clocked ports. It turns the port's select, direction, enable and mailbox-select inputs into a push strobe for the FIFO that leaves this side, a pop strobe for the FIFO that arrives at this side, and an output-enable for the read data bus. The bidirectional pad is not modelled. The block produces an enable signal and a separate data bus, and the pad logic combines them.

When mailbox select is high, the access goes to a one-word mailbox register instead of a FIFO. A write loads this side's outgoing mailbox. A read shows the mailbox that the far side writes. Each direction uses a toggle handshake. The writer flips a toggle when it writes. The reader flips an acknowledge toggle when it takes the word. Each side passes the other side's toggle through a two-stage synchronizer before using it. As a result, a mailbox flag is set in one clock domain and cleared from the other.

Top module: `bififo_port_ctrl`

## Requirements
- R1: `fifo_push` is high in a cycle exactly when `cs_n`=0, `wr_rd`=1 (1 means write), `en`=1, `mbx_sel`=0 and `fifo_full_n`=1.
- R2: `fifo_pop` is high in a cycle exactly when `cs_n`=0, `wr_rd`=0, `en`=1, `mbx_sel`=0 and `fifo_empty_n`=1.
- R3: `dout_oe` is high exactly when `cs_n`=0 and `wr_rd`=0. `dout` shows `in_mbx_data` when `mbx_sel`=1 and shows `fifo_rd_data` otherwise.
- R4: While `en`=0, no push, pop or mailbox change happens, whatever `cs_n`, `wr_rd` and `mbx_sel` do.
- R5: A mailbox write (`cs_n`=0, `wr_rd`=1, `en`=1, `mbx_sel`=1) taken while `mbx_out_flag_n`=1 has three effects at that rising edge. It loads `wr_data` into `out_mbx_data`, it inverts `out_mbx_tgl`, and it drives `mbx_out_flag_n` low.
- R6: A mailbox write presented while `mbx_out_flag_n`=0 is ignored: `out_mbx_data` and `out_mbx_tgl` keep their values.
- R7: Once `out_ack_tgl` becomes equal to `out_mbx_tgl`, `mbx_out_flag_n` returns high on the second rising edge after the change, and not on the first.
- R8: When `in_mbx_tgl` differs from `in_ack_tgl`, `mbx_in_flag_n` goes low on the second rising edge after `in_mbx_tgl` changed, and not on the first.
- R9: A mailbox read (`cs_n`=0, `wr_rd`=0, `en`=1, `mbx_sel`=1) while `mbx_in_flag_n`=0 inverts `in_ack_tgl` at that edge, so `mbx_in_flag_n` returns high. A mailbox read while `mbx_in_flag_n`=1 leaves `in_ack_tgl` unchanged.
- R10: While `rst_n`=0, both mailbox flags are high, both toggles are low and `out_mbx_data` is zero.
- R11: With `mbx_sel`=1 neither `fifo_push` nor `fifo_pop` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Port select, active low |
| wr_rd | input | 1 | 1 = write access, 0 = read access |
| en | input | 1 | Access enable, active high |
| mbx_sel | input | 1 | 1 routes the access to the mailbox |
| fifo_full_n | input | 1 | Outgoing FIFO has room when high |
| fifo_empty_n | input | 1 | Incoming FIFO has data when high |
| wr_data | input | DW | Write data from the port |
| fifo_rd_data | input | DW | Incoming FIFO output register |
| in_mbx_data | input | DW | Mailbox register written by the far side |
| in_mbx_tgl | input | 1 | Far side's write toggle (asynchronous) |
| out_ack_tgl | input | 1 | Far side's read acknowledge toggle (asynchronous) |
| fifo_push | output | 1 | Push strobe to the outgoing FIFO |
| fifo_pop | output | 1 | Pop strobe to the incoming FIFO |
| dout_oe | output | 1 | Read data bus drive enable |
| dout | output | DW | Read data bus |
| out_mbx_data | output | DW | This side's outgoing mailbox register |
| out_mbx_tgl | output | 1 | Toggle inverted on each accepted mailbox write |
| in_ack_tgl | output | 1 | Toggle inverted when incoming mail is read |
| mbx_out_flag_n | output | 1 | Low while outgoing mail is unread |
| mbx_in_flag_n | output | 1 | Low while incoming mail waits |

## Verification
The strobe decode has no state, so a decode fault appears on `fifo_push`, `fifo_pop`, `dout_oe` or `dout` in the same cycle as the input pattern that exposes it. The bench sweeps every combination of the six control inputs to find such faults. A wrong toggle or synchronizer state shows up on the mailbox flags. A flag that moves on the wrong edge, or that never returns, can be seen one or two edges after the toggle change that should move it. A missed lockout can be seen at the next edge, because `out_mbx_data` or `out_mbx_tgl` changes when it should not.

// File: rtl/bfp_pkg.sv
// Package for the port controller: the decoded access kind shared by
// the decoder and the top level.
package bfp_pkg;
    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_FIFO_WR = 3'd1,
        OP_FIFO_RD = 3'd2,
        OP_MBX_WR  = 3'd3,
        OP_MBX_RD  = 3'd4
    } port_op_e;
endpackage

// File: rtl/bfp_sync.sv
// Multi-stage synchronizer for a single level or toggle signal.
// Assumes STAGES >= 2 and an input that stays stable long enough to be sampled.
module bfp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bfp_decode.sv
// Combinational access decoder. It classifies the port controls into one
// access kind and gates the FIFO strobes with the FIFO status inputs.
// Assumes the status inputs are already synchronous to this port's clock.
module bfp_decode
    import bfp_pkg::*;
(
    input  logic     cs_n,
    input  logic     wr_rd,
    input  logic     en,
    input  logic     mbx_sel,
    input  logic     fifo_full_n,
    input  logic     fifo_empty_n,
    output port_op_e op,
    output logic     push,
    output logic     pop,
    output logic     oe,
    output logic     show_mbx
);
    // Classify the access; nothing happens without select and enable.
    always_comb begin
        op = OP_IDLE;
        if (!cs_n && en) begin
            unique case ({wr_rd, mbx_sel})
                2'b10:   op = OP_FIFO_WR;
                2'b11:   op = OP_MBX_WR;
                2'b00:   op = OP_FIFO_RD;
                default: op = OP_MBX_RD;
            endcase
        end
    end

    // Gate FIFO strobes with room/data status; drive the bus on reads.
    always_comb begin
        push     = (op == OP_FIFO_WR) && fifo_full_n;
        pop      = (op == OP_FIFO_RD) && fifo_empty_n;
        oe       = !cs_n && !wr_rd;
        show_mbx = mbx_sel;
    end
endmodule

// File: rtl/bfp_mbox_out.sv
// Outgoing mailbox: a one-word register, a write toggle sent to the far
// side, and a busy flag cleared when the far side's acknowledge toggle,
// after synchronization, matches the write toggle.
// Assumes the far side inverts its acknowledge once per word it consumes.
module bfp_mbox_out #(
    parameter int DW     = 36,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          ack_tgl_async,
    output logic [DW-1:0] mbx_data,
    output logic          mbx_tgl,
    output logic          flag_n
);
    logic ack_sync;

    bfp_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ack_tgl_async),
        .q    (ack_sync)
    );

    // Flag is high (free) while every written word has been acknowledged.
    assign flag_n = (mbx_tgl == ack_sync);

    // Capture a new word only while the previous one has been consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbx_data <= '0;
            mbx_tgl  <= 1'b0;
        end else if (wr_req && flag_n) begin
            mbx_data <= wr_data;
            mbx_tgl  <= ~mbx_tgl;
        end
    end
endmodule

// File: rtl/bfp_mbox_in.sv
// Incoming mailbox tracking: synchronizes the far side's write toggle and
// answers with an acknowledge toggle when a pending word is read.
// Assumes the far side holds its mailbox data stable until acknowledged.
module bfp_mbox_in #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic mail_tgl_async,
    output logic ack_tgl,
    output logic flag_n
);
    logic mail_sync;

    bfp_sync #(.STAGES(STAGES)) u_mail_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (mail_tgl_async),
        .q    (mail_sync)
    );

    // Mail waits (flag low) while the toggles disagree.
    assign flag_n = (mail_sync == ack_tgl);

    // Acknowledge only a read that consumes a pending word.
    always_ff @(posedge clk) begin
        if (!rst_n)                ack_tgl <= 1'b0;
        else if (rd_req && !flag_n) ack_tgl <= ~ack_tgl;
    end
endmodule

// File: rtl/bififo_port_ctrl.sv
// Top of one port's control: decode, both mailbox directions, and the
// read-bus multiplexer. FIFO memory and FIFO status synchronizers live
// outside; the pad combines dout and dout_oe into a tri-state driver.
module bififo_port_ctrl
    import bfp_pkg::*;
#(
    parameter int DW          = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wr_rd,
    input  logic          en,
    input  logic          mbx_sel,
    input  logic          fifo_full_n,
    input  logic          fifo_empty_n,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] fifo_rd_data,
    input  logic [DW-1:0] in_mbx_data,
    input  logic          in_mbx_tgl,
    input  logic          out_ack_tgl,
    output logic          fifo_push,
    output logic          fifo_pop,
    output logic          dout_oe,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] out_mbx_data,
    output logic          out_mbx_tgl,
    output logic          in_ack_tgl,
    output logic          mbx_out_flag_n,
    output logic          mbx_in_flag_n
);
    port_op_e op;
    logic     show_mbx;

    bfp_decode u_decode (
        .cs_n        (cs_n),
        .wr_rd       (wr_rd),
        .en          (en),
        .mbx_sel     (mbx_sel),
        .fifo_full_n (fifo_full_n),
        .fifo_empty_n(fifo_empty_n),
        .op          (op),
        .push        (fifo_push),
        .pop         (fifo_pop),
        .oe          (dout_oe),
        .show_mbx    (show_mbx)
    );

    bfp_mbox_out #(.DW(DW), .STAGES(SYNC_STAGES)) u_mbox_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_req       (op == OP_MBX_WR),
        .wr_data      (wr_data),
        .ack_tgl_async(out_ack_tgl),
        .mbx_data     (out_mbx_data),
        .mbx_tgl      (out_mbx_tgl),
        .flag_n       (mbx_out_flag_n)
    );

    bfp_mbox_in #(.STAGES(SYNC_STAGES)) u_mbox_in (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_req        (op == OP_MBX_RD),
        .mail_tgl_async(in_mbx_tgl),
        .ack_tgl       (in_ack_tgl),
        .flag_n        (mbx_in_flag_n)
    );

    // Read-bus source: far side's mailbox or the incoming FIFO register.
    assign dout = show_mbx ? in_mbx_data : fifo_rd_data;
endmodule

// File: rtl/bififo_port_ctrl_checker.sv
// Assertion checker for bififo_port_ctrl, attached with bind below.
module bififo_port_ctrl_checker #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          wr_rd,
    input logic          en,
    input logic          mbx_sel,
    input logic          fifo_full_n,
    input logic          fifo_empty_n,
    input logic          fifo_push,
    input logic          fifo_pop,
    input logic          dout_oe,
    input logic [DW-1:0] out_mbx_data,
    input logic          out_mbx_tgl,
    input logic          in_ack_tgl,
    input logic          mbx_out_flag_n,
    input logic          mbx_in_flag_n
);
    assert_push_needs_room_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (fifo_full_n && en && !cs_n));

    assert_pop_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (fifo_empty_n && en && !cs_n));

    assert_push_bus_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !dout_oe);

    assert_no_strobe_mailbox_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mbx_sel |-> !(fifo_push || fifo_pop));

    assert_idle_when_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (out_mbx_tgl == $past(out_mbx_tgl)) && (in_ack_tgl == $past(in_ack_tgl)));

    assert_flag_falls_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mbx_out_flag_n) |-> $past(!cs_n && en && wr_rd && mbx_sel));

    assert_mail_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mbx_out_flag_n) |-> $stable(out_mbx_data) && $stable(out_mbx_tgl));

    assert_ack_only_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack_tgl != $past(in_ack_tgl)) |-> $past(!mbx_in_flag_n));
endmodule

bind bififo_port_ctrl bififo_port_ctrl_checker #(.DW(DW)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .wr_rd         (wr_rd),
    .en            (en),
    .mbx_sel       (mbx_sel),
    .fifo_full_n   (fifo_full_n),
    .fifo_empty_n  (fifo_empty_n),
    .fifo_push     (fifo_push),
    .fifo_pop      (fifo_pop),
    .dout_oe       (dout_oe),
    .out_mbx_data  (out_mbx_data),
    .out_mbx_tgl   (out_mbx_tgl),
    .in_ack_tgl    (in_ack_tgl),
    .mbx_out_flag_n(mbx_out_flag_n),
    .mbx_in_flag_n (mbx_in_flag_n)
);

// File: tb/tb_bififo_port_ctrl.sv
module tb_bififo_port_ctrl;
    localparam int DW = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr_rd = 1'b0, en = 1'b0, mbx_sel = 1'b0;
    logic fifo_full_n = 1'b0, fifo_empty_n = 1'b0;
    logic [DW-1:0] wr_data = '0, fifo_rd_data = '0, in_mbx_data = '0;
    logic in_mbx_tgl = 1'b0, out_ack_tgl = 1'b0;
    logic fifo_push, fifo_pop, dout_oe, out_mbx_tgl, in_ack_tgl;
    logic mbx_out_flag_n, mbx_in_flag_n;
    logic [DW-1:0] dout, out_mbx_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bififo_port_ctrl #(.DW(DW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_rd(wr_rd), .en(en),
        .mbx_sel(mbx_sel), .fifo_full_n(fifo_full_n), .fifo_empty_n(fifo_empty_n),
        .wr_data(wr_data), .fifo_rd_data(fifo_rd_data), .in_mbx_data(in_mbx_data),
        .in_mbx_tgl(in_mbx_tgl), .out_ack_tgl(out_ack_tgl),
        .fifo_push(fifo_push), .fifo_pop(fifo_pop), .dout_oe(dout_oe), .dout(dout),
        .out_mbx_data(out_mbx_data), .out_mbx_tgl(out_mbx_tgl), .in_ack_tgl(in_ack_tgl),
        .mbx_out_flag_n(mbx_out_flag_n), .mbx_in_flag_n(mbx_in_flag_n)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FIFO-PORT FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ctl(input logic c, input logic w, input logic e, input logic m);
        cs_n = c; wr_rd = w; en = e; mbx_sel = m;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        in_mbx_tgl = 1'b0; out_ack_tgl = 1'b0;
        tick(); tick();
        // R10: reset state
        chk("R10 out flag", 64'(mbx_out_flag_n), 64'd1);
        chk("R10 in flag", 64'(mbx_in_flag_n), 64'd1);
        chk("R10 out tgl", 64'(out_mbx_tgl), 64'd0);
        chk("R10 ack tgl", 64'(in_ack_tgl), 64'd0);
        chk("R10 mbx data", 64'(out_mbx_data), 64'd0);
        rst_n = 1'b1;
        tick();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FIFO-PORT FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        do_reset();

        // Sweep all control/status combinations; decode is combinational.
        fifo_rd_data = 36'h1_2345_6789;
        in_mbx_data  = 36'hA_BCDE_F012;
        for (int v = 0; v < 64; v++) begin
            logic c, w, e, m, f, em;
            logic exp_push, exp_pop, exp_oe;
            {c, w, e, m, f, em} = 6'(v);
            set_ctl(c, w, e, m);
            fifo_full_n = f; fifo_empty_n = em;
            #1;
            exp_push = !c && w && e && !m && f;
            exp_pop  = !c && !w && e && !m && em;
            exp_oe   = !c && !w;
            chk("R1 push", 64'(fifo_push), 64'(exp_push));
            chk("R2 pop", 64'(fifo_pop), 64'(exp_pop));
            chk("R3 oe", 64'(dout_oe), 64'(exp_oe));
            chk("R3 dout", 64'(dout), m ? 64'(in_mbx_data) : 64'(fifo_rd_data));
            if (m) chk("R11 no strobe", 64'({fifo_push, fifo_pop}), 64'd0);
            if (!e) chk("R4 no strobe", 64'({fifo_push, fifo_pop}), 64'd0);
            tick();
        end

        do_reset();

        // R4: disabled mailbox write leaves the register untouched.
        wr_data = 36'h5_5555_AAAA;
        set_ctl(1'b0, 1'b1, 1'b0, 1'b1);
        tick();
        chk("R4 data kept", 64'(out_mbx_data), 64'd0);
        chk("R4 tgl kept", 64'(out_mbx_tgl), 64'd0);
        chk("R4 flag kept", 64'(mbx_out_flag_n), 64'd1);

        // R5: accepted mailbox write.
        wr_data = 36'h9_8765_4321;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        tick();
        chk("R5 data", 64'(out_mbx_data), 64'h9_8765_4321);
        chk("R5 tgl", 64'(out_mbx_tgl), 64'd1);
        chk("R5 flag low", 64'(mbx_out_flag_n), 64'd0);

        // R6: second write while flag low is ignored.
        wr_data = 36'h0_F0F0_F0F0;
        tick();
        chk("R6 data kept", 64'(out_mbx_data), 64'h9_8765_4321);
        chk("R6 tgl kept", 64'(out_mbx_tgl), 64'd1);
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);

        // R7: acknowledge takes two edges.
        out_ack_tgl = 1'b1;
        tick();
        chk("R7 still low after 1 edge", 64'(mbx_out_flag_n), 64'd0);
        tick();
        chk("R7 high after 2 edges", 64'(mbx_out_flag_n), 64'd1);

        // R5 again: after the acknowledge a new write is accepted.
        wr_data = 36'h3_3333_0000;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        tick();
        chk("R5 rewrite data", 64'(out_mbx_data), 64'h3_3333_0000);
        chk("R5 rewrite tgl", 64'(out_mbx_tgl), 64'd0);
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);

        // R8: incoming mail flag after two edges.
        in_mbx_data = 36'hC_0FFE_E123;
        in_mbx_tgl = 1'b1;
        tick();
        chk("R8 still high after 1 edge", 64'(mbx_in_flag_n), 64'd1);
        tick();
        chk("R8 low after 2 edges", 64'(mbx_in_flag_n), 64'd0);

        // R9 and R3: mailbox read shows the word and acknowledges it.
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        #1;
        chk("R3 mbx dout", 64'(dout), 64'hC_0FFE_E123);
        chk("R3 mbx oe", 64'(dout_oe), 64'd1);
        tick();
        chk("R9 ack toggled", 64'(in_ack_tgl), 64'd1);
        chk("R9 flag high", 64'(mbx_in_flag_n), 64'd1);
        tick();
        chk("R9 no ack without mail", 64'(in_ack_tgl), 64'd1);
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule